// File: doc/BRIEF.md
# Dynamic Bus-Sizing Transfer Sequencer

This block is a bus master that moves a single operand of one, two or four bytes between an internal requester and an external asynchronous bus. Each responding device states its own port width (8, 16 or 32 bits) through a pair of active-low acknowledge inputs. The same inputs also end the bus cycle. The sequencer does not know the width in advance. It splits each operand on the fly into as many bus cycles as the start address and the reported width require. The next address and the bytes still owed are recomputed after every acknowledged cycle.

For writes, the outgoing bytes are replicated across the data lanes so that a port of any width finds its byte on the lanes it owns. For reads, bytes are collected from the lanes that the reported width implies and are assembled into a right-justified result. The acknowledge pair is asynchronous. It passes through a two-flop synchronizer and a stability filter before the control logic acts on it. An instruction fetch at an odd address is refused with an error pulse and starts no bus cycle.

Top module: `bus_size_seq`

## Requirements
- R1: After reset, `bus_as`, `bus_ds`, `done` and `err` are low and `req_ready` is high.
- R2: A request is taken while `req_ready` is high. `bus_as` rises with the address, and `bus_ds` rises one cycle later, only while `bus_as` is high. Both strobes and the address stay unchanged until a valid acknowledge is seen.
- R3: The acknowledge pair `ack_n` is active low: 11 means wait, 10 means an 8-bit port, 01 means a 16-bit port, 00 means a 32-bit port. A code is used only after two synchronizer flops and two equal samples. An acknowledge that arrives while no cycle is open has no effect.
- R4: Each acknowledged cycle moves min(remaining, P − (address mod P)) bytes, where P is the reported port width in bytes. The next cycle's address is the old address plus that count.
- R5: `bus_siz` shows the bytes still to move: 01 means one, 10 means two, 11 means three, 00 means four.
- R6: Write data lanes are numbered 0..3 from bits 31:24 down to bits 7:0. A 32-bit port takes the byte for address offset k on lane k. A 16-bit port uses lanes 0–1, and an 8-bit port uses lane 0. Replication puts the correct next byte on every lane that some width could use.
- R7: Read bytes are taken from lane base+j, where the base is the address offset for a 32-bit port, address bit 0 for a 16-bit port, and 0 for an 8-bit port. `rdata` holds the operand right-justified, with the lowest-addressed byte most significant.
- R8: `done` pulses for exactly one cycle after the final cycle is acknowledged, and `rdata` is valid in that cycle. One `done` is produced per accepted transfer.
- R9: A fetch request (`req_fetch` high) at an odd address gives a one-cycle `err` pulse. No strobe is asserted and no `done` follows.
- R10: After each acknowledge, both strobes go low. The next cycle starts only after the synchronized acknowledge has returned to wait.
- R11: `req_size` encoding: 01 is one byte, 10 is two bytes, 00 is four bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_size | input | 2 | Operand size (R11) |
| req_addr | input | AW | Byte address of the operand |
| req_wdata | input | 32 | Write operand, right-justified |
| req_ready | output | 1 | Sequencer is idle and can take a request |
| bus_addr | output | AW | Bus address of the current cycle |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_siz | output | 2 | Bytes remaining (R5) |
| bus_dout | output | 32 | Replicated write data lanes |
| bus_din | input | 32 | Read data lanes |
| ack_n | input | 2 | Asynchronous size acknowledge, active low |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Misaligned-fetch error pulse |
| rdata | output | 32 | Gathered read operand |

## Verification
Every operand size is written and then read back at all four byte offsets, against devices that report 32-, 16- and 8-bit widths. This separates errors in the split count, the address step, the lane choice and the replication pattern. Each of these shows up as a wrong byte in the bench's memory model, a wrong cycle count or a wrong gathered word. The device model checks the address and the remaining size on every cycle against its own running count, so a fault in one step of a split is traced to that step. An aligned fetch, a misaligned fetch and acknowledges pushed onto an idle bus show the difference between a refused request, a normal request and a stray handshake.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_REL} seq_state_e;

  localparam logic [1:0] ACK_WAIT = 2'b11;
  localparam logic [1:0] ACK_P8   = 2'b10;
  localparam logic [1:0] ACK_P16  = 2'b01;
  localparam logic [1:0] ACK_P32  = 2'b00;

  // Port width in bytes implied by a synchronized acknowledge code (0 = wait).
  function automatic logic [2:0] port_bytes(input logic [1:0] code);
    case (code)
      ACK_P8:  port_bytes = 3'd1;
      ACK_P16: port_bytes = 3'd2;
      ACK_P32: port_bytes = 3'd4;
      default: port_bytes = 3'd0;
    endcase
  endfunction

  // Offset of the address inside a port of the given width.
  function automatic logic [1:0] port_offset(input logic [1:0] alo, input logic [2:0] pb);
    if (pb == 3'd4)      port_offset = alo;
    else if (pb == 3'd2) port_offset = {1'b0, alo[0]};
    else                 port_offset = 2'd0;
  endfunction

  // Bytes moved by one cycle: limited by what is left and by the port's room.
  function automatic logic [2:0] chunk_bytes(input logic [1:0] alo, input logic [2:0] rem,
                                             input logic [2:0] pb);
    logic [2:0] room;
    room = pb - {1'b0, port_offset(alo, pb)};
    chunk_bytes = (rem < room) ? rem : room;
  endfunction

endpackage

// File: rtl/bsz_ack_sync.sv
module bsz_ack_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] code_q
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  // Synchronizer stages, idle value is all ones (inactive low inputs).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
      prev_q <= '1;
      code_q <= '1;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[STAGES-1];
      // Accept a code only when two successive samples agree.
      code_q <= (chain[STAGES-1] == prev_q) ? prev_q : '1;
    end
  end

endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes
  import bsz_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    alo,
  input  logic [2:0]    pb,
  input  logic [2:0]    nbytes,
  input  logic [DW-1:0] wsh,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] acc_in,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] acc_out
);
  localparam int NL = DW / 8;

  // Write replication: lane k carries the byte a 32-bit port wants there;
  // lanes below the offset carry what a 16-bit or 8-bit port would want.
  always_comb begin
    dout = '0;
    for (int k = 0; k < NL; k++) begin
      int j;
      if (k >= int'(alo))            j = k - int'(alo);
      else if (k >= int'(alo[0]))    j = k - int'(alo[0]);
      else                           j = 0;
      dout[DW-1-8*k -: 8] = wsh[DW-1-8*j -: 8];
    end
  end

  // Read gather: append the bytes of this cycle below those already held.
  always_comb begin
    int base;
    base    = int'(port_offset(alo, pb));
    acc_out = acc_in;
    for (int j = 0; j < NL; j++) begin
      if (j < int'(nbytes) && (base + j) < NL)
        acc_out = {acc_out[DW-9:0], din[DW-1-8*(base+j) -: 8]};
    end
  end

endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
  import bsz_pkg::*;
#(
  parameter int AW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_fetch,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_as,
  output logic          bus_ds,
  output logic          bus_rw,
  output logic [1:0]    bus_siz,
  output logic [31:0]   bus_dout,
  input  logic [31:0]   bus_din,
  input  logic [1:0]    ack_n,
  output logic          done,
  output logic          err,
  output logic [31:0]   rdata
);
  localparam int DW = 32;

  seq_state_e    state;
  logic [2:0]    rem_r;
  logic [DW-1:0] wsh_r, acc_r, acc_nx;
  logic [1:0]    ack_q;
  logic [2:0]    pb, nb, req_bytes;

  bsz_ack_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ack_n), .code_q(ack_q)
  );

  assign pb        = port_bytes(ack_q);
  assign nb        = chunk_bytes(bus_addr[1:0], rem_r, pb);
  assign req_bytes = (req_size == 2'b00) ? 3'd4 : {1'b0, req_size};

  bsz_lanes #(.DW(DW)) u_lanes (
    .alo(bus_addr[1:0]), .pb(pb), .nbytes(nb), .wsh(wsh_r), .din(bus_din),
    .acc_in(acc_r), .dout(bus_dout), .acc_out(acc_nx)
  );

  assign req_ready = (state == ST_IDLE);
  assign bus_siz   = rem_r[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bus_addr <= '0;
      bus_as   <= 1'b0;
      bus_ds   <= 1'b0;
      bus_rw   <= 1'b1;
      rem_r    <= '0;
      wsh_r    <= '0;
      acc_r    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_fetch && req_addr[0]) begin
              err <= 1'b1;
            end else begin
              bus_addr <= req_addr;
              rem_r    <= req_bytes;
              wsh_r    <= req_wdata << {3'd4 - req_bytes, 3'b000};
              acc_r    <= '0;
              bus_rw   <= ~req_write;
              bus_as   <= 1'b1;
              state    <= ST_BUS;
            end
          end
        end
        ST_BUS: begin
          bus_ds <= 1'b1;
          if (bus_ds && pb != 3'd0) begin
            bus_addr <= bus_addr + AW'(nb);
            rem_r    <= rem_r - nb;
            wsh_r    <= wsh_r << {nb, 3'b000};
            acc_r    <= acc_nx;
            bus_as   <= 1'b0;
            bus_ds   <= 1'b0;
            state    <= ST_REL;
            if (rem_r == nb) begin
              done <= 1'b1;
              if (bus_rw) rdata <= acc_nx;
            end
          end
        end
        ST_REL: begin
          if (ack_q == ACK_WAIT) begin
            if (rem_r == 3'd0) begin
              state <= ST_IDLE;
            end else begin
              bus_as <= 1'b1;
              state  <= ST_BUS;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: data strobe only inside an address strobe
  p_ds_within_as_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ds |-> bus_as);

  // R2: cycle held open with a stable address while waiting
  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUS && ack_q == ACK_WAIT) |=> (bus_as && $stable(bus_addr)));

  // R10: no new cycle while the previous acknowledge is still seen
  p_release_wait_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REL && ack_q != ACK_WAIT) |=> !bus_as);

  // R3: an idle bus ignores acknowledges
  p_idle_ignores_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !req_valid) |=> !bus_as);

  // R5: an open cycle always has bytes left to move
  p_siz_live_r5: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> (rem_r != 3'd0));

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a refused fetch produces no bus activity and no completion
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> (!bus_as && !done));

endmodule

// File: tb/bus_size_seq_tb.sv
module bus_size_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0, req_fetch = 0;
  logic [1:0]  req_size = 2'b01;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, bus_as, bus_ds, bus_rw, done, err;
  logic [31:0] bus_addr, bus_dout, rdata;
  logic [31:0] bus_din = '0;
  logic [1:0]  bus_siz;
  logic [1:0]  ack_n = 2'b11;

  always #2 clk = ~clk;

  bus_size_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_fetch(req_fetch), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .bus_addr(bus_addr),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw), .bus_siz(bus_siz),
    .bus_dout(bus_dout), .bus_din(bus_din), .ack_n(ack_n), .done(done),
    .err(err), .rdata(rdata)
  );

  typedef struct {
    bit          rd;
    logic [31:0] addr;
    int          sz;
    logic [31:0] data;
    int          cyc;
  } item_t;

  item_t       sb_q[$];
  logic [7:0]  mem [256];
  int checks = 0, errors = 0;
  int cyc_cnt = 0, issued = 0, completed = 0;
  int dev_rem = 0;
  logic [31:0] dev_addr = '0;
  bit force_ack = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int port_of(input logic [31:0] a);
    case (a[7:6])
      2'd1:    return 2;
      2'd2:    return 1;
      default: return 4;
    endcase
  endfunction

  function automatic int step_of(input logic [31:0] a, input int r);
    int pb, off, room;
    pb = port_of(a);
    off = (pb == 1) ? 0 : int'(a) % pb;
    room = pb - off;
    return (r < room) ? r : room;
  endfunction

  function automatic int exp_cycles(input logic [31:0] a, input int sz);
    int r, c, n;
    r = sz; c = 0;
    while (r > 0) begin
      n = step_of(a, r);
      a = a + n; r = r - n; c++;
    end
    return c;
  endfunction

  // Device model: reports its width by address region, answers after a delay.
  initial begin
    forever begin
      @(negedge clk);
      if (bus_as && bus_ds) begin
        int pb, n, base, rem;
        logic [31:0] a;
        a   = bus_addr;
        rem = (bus_siz == 2'b00) ? 4 : int'(bus_siz);
        chk(a == dev_addr, "R4 cycle address", a, dev_addr);
        chk(rem == dev_rem, "R5 remaining size", rem, dev_rem);
        repeat (2) @(negedge clk);
        chk(bus_as && bus_ds && bus_addr == a, "R2 strobes held while waiting", {30'd0, bus_as, bus_ds}, 32'd3);
        pb   = port_of(a);
        n    = step_of(a, rem);
        base = (pb == 1) ? 0 : int'(a) % pb;
        bus_din = '0;
        for (int j = 0; j < n; j++) begin
          if (!bus_rw) mem[(a + j) & 32'hFF] = bus_dout[31-8*(base+j) -: 8];
          else         bus_din[31-8*(base+j) -: 8] = mem[(a + j) & 32'hFF];
        end
        ack_n = (pb == 4) ? 2'b00 : (pb == 2) ? 2'b01 : 2'b10;
        cyc_cnt++;
        dev_addr = a + n;
        dev_rem  = rem - n;
        while (bus_as) @(negedge clk);
        ack_n = 2'b11;
        @(negedge clk);
        chk(!bus_as, "R10 no restart before acknowledge release", {31'd0, bus_as}, 32'd0);
      end else begin
        ack_n = force_ack ? 2'b00 : 2'b11;
      end
    end
  end

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(cyc_cnt == it.cyc, "R4 bus cycle count", cyc_cnt, it.cyc);
          if (it.rd) begin
            chk(rdata == it.data, "R7 gathered read data", rdata, it.data);
          end else begin
            for (int j = 0; j < it.sz; j++) begin
              logic [7:0] eb;
              eb = it.data[8*(it.sz-1-j) +: 8];
              chk(mem[(it.addr + j) & 32'hFF] == eb, "R6 written byte", {24'd0, mem[(it.addr + j) & 32'hFF]}, {24'd0, eb});
            end
          end
          completed++;
        end
      end
    end
  end

  task automatic do_req(input bit wr, input bit fetch, input int sz, input logic [31:0] a, input logic [31:0] d);
    item_t it;
    it.rd = !wr; it.addr = a; it.sz = sz; it.cyc = exp_cycles(a, sz);
    it.data = '0;
    if (wr) begin
      it.data = (sz == 4) ? d : (d & ((32'd1 << (8*sz)) - 1));
    end else begin
      for (int j = 0; j < sz; j++) it.data = {it.data[23:0], mem[(a + j) & 32'hFF]};
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sb_q.push_back(it);
    dev_addr = a; dev_rem = sz; cyc_cnt = 0; issued++;
    req_valid = 1; req_write = wr; req_fetch = fetch; req_addr = a;
    req_size = (sz == 4) ? 2'b00 : 2'(sz); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_fetch = 0;
    while (completed < issued) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(req_ready && !bus_as && !bus_ds && !done && !err, "R1 reset state",
        {27'd0, req_ready, bus_as, bus_ds, done, err}, 32'h10);

    // R3: acknowledges on an idle bus are ignored
    force_ack = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!bus_as && !done, "R3 idle acknowledge ignored", {30'd0, bus_as, done}, 32'd0);
    end
    force_ack = 0;
    repeat (6) @(negedge clk);

    // R9: misaligned fetch is refused
    req_valid = 1; req_fetch = 1; req_write = 0; req_size = 2'b10; req_addr = 32'h43;
    @(negedge clk);
    req_valid = 0; req_fetch = 0;
    chk(err && !bus_as, "R9 misaligned fetch error", {30'd0, err, bus_as}, 32'd2);
    @(negedge clk);
    chk(!err && !bus_as && req_ready, "R9 error is one pulse, no cycle", {29'd0, err, bus_as, req_ready}, 32'd1);
    repeat (4) @(negedge clk);
    chk(!bus_as && !done, "R9 no bus cycle after refused fetch", {30'd0, bus_as, done}, 32'd0);

    // R11, R7: aligned fetches and a preloaded read on each width
    do_req(0, 1, 4, 32'h42, '0);
    do_req(0, 1, 2, 32'hA2, '0);
    do_req(0, 0, 4, 32'hC1, '0);

    // R4, R5, R6, R7, R8: every size at every offset on every width
    for (int r = 0; r < 3; r++) begin
      for (int si = 0; si < 3; si++) begin
        for (int off = 0; off < 4; off++) begin
          int sz;
          logic [31:0] a, d;
          sz = (si == 0) ? 1 : (si == 1) ? 2 : 4;
          a  = 32'(r * 64 + 8 + si * 16 + off);
          d  = 32'hA1B2C3D4 ^ (a * 32'h01030507);
          do_req(1, 0, sz, a, d);
          do_req(0, 0, sz, a, '0);
        end
      end
    end

    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0 && completed == issued, "R8 one done per transfer", completed, issued);
    finish_run();
  end

endmodule